// File: doc/BRIEF.md
# System Control Register File

This block holds the privileged control registers of a processor core. Each register is reached through a 5-bit register number and a 3-bit select. Software writes go in through a 32-bit write port and reads come out through a 32-bit read port. On every write the target register passes the data through its own write mask and keeps certain bits of its previous contents. Bits that are in neither set are cleared. A few registers are read-only constants. The link-address register is presented shifted. Registers with no storage read as zero.

Two side effects leave the block. First, the mode flags (exception level, error level, user mode) are taken from a status write and reflected back into status reads. Second, when a status write turns interrupt enable on while an enabled, unmasked request is pending, a hardware interrupt request is raised and held until a status write turns interrupt enable off. A write that changes the address-space ID in the entry-high register produces a one-cycle flush pulse. Six hardware interrupt lines are copied into cause bits 15:10 on every clock.

The write port is a valid/ready interface. `wr_ready` is always high, so a write is taken on every clock edge where `wr_valid` is high and there is no back-pressure. Reads are combinational from the register state, with no handshake.

Top module: `sysctl_regfile`

## Requirements
- R1: A select other than 0 is legal only as select 1 of register 16 (second config word) or register 28 (data tag word). Any other select makes a write do nothing and a read return zero.
- R2: A write to register 0 (index) stores only bits 3:0 and keeps bit 31. Bits 30:4 always read as zero.
- R3: Registers 2 and 3 take the write through mask 0x3FFFFFFF. Register 5 takes mask 0x01FFE000. Register 6 takes only bits 3:0.
- R4: Register 4 (context) keeps bits 31:24, takes bits 23:4 from the write, and reads bits 3:0 as zero.
- R5: Register 10 (entry-high) takes mask 0xFFFFF0FF. `asid_flush` is high for exactly the one cycle after a write whose bits 7:0 differ from the stored bits 7:0, and is low otherwise.
- R6: Register 12 (status) stores the write through mask 0xFA78FF01. Bits 1, 2 and 4 of each status write set `mode_exl`, `mode_erl` and `mode_um` in the following cycle, and a status read returns those flags in bits 1, 2 and 4. The flags change on no other write.
- R7: `hw_irq_req` rises in the cycle after a status write that meets all of these conditions: it sets bit 0 while the stored bit 0 is 0, its bits 1 and 2 are 0, `debug_mode` is low, and (written status AND 0x0000FF00 AND stored cause) is nonzero.
- R8: `hw_irq_req` falls in the cycle after a status write that clears bit 0 while the stored bit 0 is 1. Otherwise it holds its value. It resets to 0.
- R9: A write to register 13 (cause) changes only bits 9:8 and 23:22 and keeps bits under mask 0xB000F87C. Cause bits 15:10 copy `hw_irq_lines` on every clock, with one cycle of delay.
- R10: Register 19 takes mask 0x40FF0FF8. Register 17 (link address) stores all 32 bits and reads back shifted right by 4.
- R11: Register 16 select 0 keeps bits under mask 0xFE17FF80 and takes only bit 0 from a write, starting from `CFG0_RST`. Register 16 select 1 reads `CFG1_VAL` and register 15 reads `PRID_VAL`, and writes change neither. Register 28 select 1 reads zero.
- R12: Registers 1, 7, 8, 20 to 23, 25 to 27 and 29 read zero, and writes to them have no effect.
- R13: Registers 9, 11, 14, 18, 24, 30 and 31 store all 32 bits. Register 28 select 0 takes mask 0xFFFFFCF6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write accepted, always high |
| wr_reg | input | 5 | Write register number |
| wr_sel | input | 3 | Write select |
| wr_data | input | 32 | Write data |
| rd_reg | input | 5 | Read register number |
| rd_sel | input | 3 | Read select |
| rd_data | output | 32 | Read data, combinational |
| hw_irq_lines | input | 6 | Hardware interrupt lines into cause bits 15:10 |
| debug_mode | input | 1 | Debug mode active, blocks interrupt raising |
| hw_irq_req | output | 1 | Hardware interrupt request level |
| asid_flush | output | 1 | One-cycle pulse on address-space ID change |
| mode_exl | output | 1 | Exception-level flag |
| mode_erl | output | 1 | Error-level flag |
| mode_um | output | 1 | User-mode flag |

## Verification
The assertions assume that after reset the write fields, read address, `debug_mode` and `wr_valid` carry known values. Each interrupt edge and each flush pulse is traced back to the status or entry-high write in the cycle before. The stimulus changes every input only just after the falling clock edge and always with defined values, so each write and read address is stable over a whole rising edge. Directed sequences cover the interrupt-enable gating by the level flags, debug mode, and software and hardware cause bits. A long random phase aims mostly at select 0 and sometimes at the illegal and alternate selects.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW      = 32;
  localparam int REG_W   = 5;
  localparam int SEL_W   = 3;
  localparam int NREG    = 1 << REG_W;
  localparam int NSLOT   = NREG + 2;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int HW_N    = 6;
  localparam int HW_LO   = 10;

  // slot numbers: select-0 registers use their own number, the two
  // alternate selects sit after them
  localparam logic [SLOT_W-1:0] S_STATUS  = SLOT_W'(12);
  localparam logic [SLOT_W-1:0] S_PRID    = SLOT_W'(15);
  localparam logic [SLOT_W-1:0] S_LINK    = SLOT_W'(17);
  localparam logic [SLOT_W-1:0] S_CFG_ALT = SLOT_W'(NREG);
  localparam logic [SLOT_W-1:0] S_TAG_ALT = SLOT_W'(NREG + 1);

  localparam int N_ENTRYHI = 10;
  localparam int N_STATUS  = 12;
  localparam int N_CAUSE   = 13;
  localparam int N_CONFIG  = 16;
  localparam int N_TAG     = 28;

  localparam logic [DW-1:0] STATUS_WMASK = 32'hFA78_FF01;
  localparam logic [DW-1:0] IRQ_MASK_BITS = 32'h0000_FF00;

  // bits a write may set
  function automatic logic [DW-1:0] slot_wmask(input int s);
    case (s)
      0:                          slot_wmask = 32'h0000_000F;
      2, 3:                       slot_wmask = 32'h3FFF_FFFF;
      4:                          slot_wmask = 32'h00FF_FFF0;
      5:                          slot_wmask = 32'h01FF_E000;
      6:                          slot_wmask = 32'h0000_000F;
      9, 11, 14, 17, 18, 24, 30, 31: slot_wmask = 32'hFFFF_FFFF;
      10:                         slot_wmask = 32'hFFFF_F0FF;
      12:                         slot_wmask = STATUS_WMASK;
      13:                         slot_wmask = 32'h00C0_0300;
      16:                         slot_wmask = 32'h0000_0001;
      19:                         slot_wmask = 32'h40FF_0FF8;
      28:                         slot_wmask = 32'hFFFF_FCF6;
      default:                    slot_wmask = '0;
    endcase
  endfunction

  // bits a write leaves as they were
  function automatic logic [DW-1:0] slot_kmask(input int s);
    case (s)
      0:       slot_kmask = 32'h8000_0000;
      4:       slot_kmask = 32'hFF00_0000;
      13:      slot_kmask = 32'hB000_F87C;
      16:      slot_kmask = 32'hFE17_FF80;
      default: slot_kmask = '0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
  import sysctl_pkg::*;
(
  input  logic [REG_W-1:0]  rnum,
  input  logic [SEL_W-1:0]  sel,
  output logic              ok,
  output logic [SLOT_W-1:0] slot
);
  logic has_alt;

  always_comb begin
    has_alt = (rnum == REG_W'(N_CONFIG)) || (rnum == REG_W'(N_TAG));
    ok      = (sel == '0) || ((sel == SEL_W'(1)) && has_alt);
    if (sel == '0)
      slot = SLOT_W'(rnum);
    else if (rnum == REG_W'(N_CONFIG))
      slot = S_CFG_ALT;
    else
      slot = S_TAG_ALT;
  end
endmodule

// File: rtl/sysctl_irq_ctl.sv
module sysctl_irq_ctl
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_wr,
  input  logic [DW-1:0] st_wdata,
  input  logic          st_old_ie,
  input  logic [DW-1:0] cause_q,
  input  logic          debug_mode,
  output logic          irq_q
);
  logic [DW-1:0] st_new;
  logic          pend, raise, drop;

  always_comb begin
    st_new = st_wdata & STATUS_WMASK;
    pend   = |(st_new & cause_q & IRQ_MASK_BITS);
    raise  = st_wr && st_new[0] && !st_old_ie && !st_wdata[1] &&
             !st_wdata[2] && !debug_mode && pend;
    drop   = st_wr && !st_wdata[0] && st_old_ie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (raise) irq_q <= 1'b1;
    else if (drop)  irq_q <= 1'b0;
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [31:0] CFG0_RST = 32'h8000_8083,
  parameter logic [31:0] CFG1_VAL = 32'h1E00_0000,
  parameter logic [31:0] PRID_VAL = 32'h0001_8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [4:0]  wr_reg,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_reg,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic [5:0]  hw_irq_lines,
  input  logic        debug_mode,
  output logic        hw_irq_req,
  output logic        asid_flush,
  output logic        mode_exl,
  output logic        mode_erl,
  output logic        mode_um
);
  logic              wr_ok, rd_ok, wr_fire;
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [NSLOT-1:0]  wr_hit;
  logic [DW-1:0]     slot_q [NSLOT];
  logic              flush_q, exl_q, erl_q, um_q;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  sysctl_addr_dec u_wdec (.rnum(wr_reg), .sel(wr_sel), .ok(wr_ok), .slot(wr_slot));
  sysctl_addr_dec u_rdec (.rnum(rd_reg), .sel(rd_sel), .ok(rd_ok), .slot(rd_slot));

  assign wr_hit = (wr_fire && wr_ok) ? (NSLOT'(1) << wr_slot) : '0;

  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_slot
      if (slot_wmask(s) != '0) begin : g_live
        localparam logic [DW-1:0] WM = slot_wmask(s);
        localparam logic [DW-1:0] KM = slot_kmask(s);
        localparam logic [DW-1:0] RV = (s == N_CONFIG) ? CFG0_RST : '0;
        logic [DW-1:0] nxt;
        always_comb begin
          nxt = slot_q[s];
          if (wr_hit[s]) nxt = (slot_q[s] & KM) | (wr_data & WM);
          if (s == N_CAUSE) nxt[HW_LO +: HW_N] = hw_irq_lines;
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) slot_q[s] <= RV;
          else        slot_q[s] <= nxt;
        end
      end else begin : g_none
        assign slot_q[s] = '0;
      end
    end
  endgenerate

  // mode flags and flush pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      exl_q   <= 1'b0;
      erl_q   <= 1'b0;
      um_q    <= 1'b0;
    end else begin
      flush_q <= wr_hit[N_ENTRYHI] && (wr_data[7:0] != slot_q[N_ENTRYHI][7:0]);
      if (wr_hit[N_STATUS]) begin
        exl_q <= wr_data[1];
        erl_q <= wr_data[2];
        um_q  <= wr_data[4];
      end
    end
  end

  sysctl_irq_ctl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_wr     (wr_hit[N_STATUS]),
    .st_wdata  (wr_data),
    .st_old_ie (slot_q[N_STATUS][0]),
    .cause_q   (slot_q[N_CAUSE]),
    .debug_mode(debug_mode),
    .irq_q     (hw_irq_req)
  );

  always_comb begin
    rd_data = '0;
    if (rd_ok) begin
      case (rd_slot)
        S_STATUS:  rd_data = slot_q[N_STATUS] |
                             {27'd0, um_q, 1'b0, erl_q, exl_q, 1'b0};
        S_PRID:    rd_data = PRID_VAL;
        S_LINK:    rd_data = slot_q[S_LINK] >> 4;
        S_CFG_ALT: rd_data = CFG1_VAL;
        default:   rd_data = slot_q[rd_slot];
      endcase
    end
  end

  assign asid_flush = flush_q;
  assign mode_exl   = exl_q;
  assign mode_erl   = erl_q;
  assign mode_um    = um_q;
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic [4:0]  wr_reg,
  input logic [2:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic [4:0]  rd_reg,
  input logic [2:0]  rd_sel,
  input logic [31:0] rd_data,
  input logic        debug_mode,
  input logic        hw_irq_req,
  input logic        asid_flush,
  input logic        mode_exl,
  input logic        mode_erl,
  input logic        mode_um
);
  logic st_wr, eh_wr;
  assign st_wr = wr_valid && wr_reg == 5'd12 && wr_sel == 3'd0;
  assign eh_wr = wr_valid && wr_reg == 5'd10 && wr_sel == 3'd0;

  p_badsel_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel != 3'd0 && rd_reg != 5'd16 && rd_reg != 5'd28) |-> rd_data == 32'd0);

  p_index_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reg == 5'd0 && rd_sel == 3'd0) |-> rd_data[30:4] == 27'd0);

  p_ctx_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reg == 5'd4 && rd_sel == 3'd0) |-> rd_data[3:0] == 4'd0);

  p_flush_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    asid_flush |-> $past(eh_wr));

  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> $stable({mode_um, mode_erl, mode_exl}));

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hw_irq_req) |-> $past(st_wr && wr_data[0] && !debug_mode));

  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hw_irq_req) |-> $past(st_wr && !wr_data[0]));
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_reg(wr_reg),
  .wr_sel(wr_sel), .wr_data(wr_data), .rd_reg(rd_reg), .rd_sel(rd_sel),
  .rd_data(rd_data), .debug_mode(debug_mode), .hw_irq_req(hw_irq_req),
  .asid_flush(asid_flush), .mode_exl(mode_exl), .mode_erl(mode_erl),
  .mode_um(mode_um)
);

// File: tb/sim_sysctl_regfile.sv
`timescale 1ns/100ps
module sim_sysctl_regfile;
  localparam logic [31:0] C0R = 32'h8000_8083;
  localparam logic [31:0] C1V = 32'h1E00_0000;
  localparam logic [31:0] PIV = 32'h0001_8000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [4:0] wr_reg = '0, rd_reg = '0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [5:0] hw_irq_lines = '0;
  logic debug_mode = 1'b0;
  logic hw_irq_req, asid_flush, mode_exl, mode_erl, mode_um;

  always #2.5 clk = ~clk;

  sysctl_regfile u0 (.*);

  int tests = 0, fails = 0;
  bit started = 0;

  // behavioural reference state
  logic [31:0] m [0:31];
  logic [31:0] m_cfg0;
  logic e_exl, e_erl, e_um, e_irq, e_flush;

  function automatic bit sel_legal(input [4:0] r, input [2:0] s);
    return s == 0 || (s == 1 && (r == 16 || r == 28));
  endfunction

  function automatic logic [31:0] m_read(input [4:0] r, input [2:0] s);
    if (!sel_legal(r, s)) return 32'd0;
    if (s == 1) return (r == 16) ? C1V : 32'd0;
    case (r)
      12: return m[12] | {27'd0, e_um, 1'b0, e_erl, e_exl, 1'b0};
      15: return PIV;
      16: return m_cfg0;
      17: return m[17] >> 4;
      default: return m[r];
    endcase
  endfunction

  function automatic string tag_of(input [4:0] r, input [2:0] s);
    if (!sel_legal(r, s)) return "R1";
    if (s == 1) return "R11";
    case (r)
      0: return "R2";
      2, 3, 5, 6: return "R3";
      4: return "R4";
      10: return "R5";
      12: return "R6";
      13: return "R9";
      17, 19: return "R10";
      15, 16: return "R11";
      9, 11, 14, 18, 24, 28, 30, 31: return "R13";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m[i] = 32'd0;
      m_cfg0 = C0R;
      {e_exl, e_erl, e_um, e_irq, e_flush} = '0;
    end else begin
      e_flush = 1'b0;
      if (wr_valid && sel_legal(wr_reg, wr_sel) && wr_sel == 0) begin
        case (wr_reg)
          0: m[0] = {m[0][31], 27'd0, wr_data[3:0]};
          2, 3: m[wr_reg] = {2'b00, wr_data[29:0]};
          4: m[4] = {m[4][31:24], wr_data[23:4], 4'd0};
          5: m[5] = wr_data & 32'h01FF_E000;
          6: m[6] = {28'd0, wr_data[3:0]};
          9, 11, 14, 17, 18, 24, 30, 31: m[wr_reg] = wr_data;
          10: begin
            e_flush = wr_data[7:0] != m[10][7:0];
            m[10] = wr_data & 32'hFFFF_F0FF;
          end
          12: begin
            logic [31:0] nv;
            nv = wr_data & 32'hFA78_FF01;
            if (nv[0] && !m[12][0] && !wr_data[1] && !wr_data[2] && !debug_mode
                && ((nv & m[13] & 32'h0000_FF00) != 0))
              e_irq = 1'b1;
            else if (!wr_data[0] && m[12][0])
              e_irq = 1'b0;
            e_exl = wr_data[1]; e_erl = wr_data[2]; e_um = wr_data[4];
            m[12] = nv;
          end
          13: m[13] = (m[13] & 32'hB000_F87C) | (wr_data & 32'h00C0_0300);
          16: m_cfg0 = (m_cfg0 & 32'hFE17_FF80) | {31'd0, wr_data[0]};
          19: m[19] = wr_data & 32'h40FF_0FF8;
          28: m[28] = wr_data & 32'hFFFF_FCF6;
          default: ;
        endcase
      end
      m[13][15:10] = hw_irq_lines;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(tag_of(rd_reg, rd_sel), $sformatf("read reg %0d sel %0d", rd_reg, rd_sel),
          rd_data, m_read(rd_reg, rd_sel));
      chk("R5", "asid_flush", {31'd0, asid_flush}, {31'd0, e_flush});
      chk(e_irq ? "R7" : "R8", "hw_irq_req", {31'd0, hw_irq_req}, {31'd0, e_irq});
      chk("R6", "mode flags", {29'd0, mode_um, mode_erl, mode_exl}, {29'd0, e_um, e_erl, e_exl});
      chk("R1", "wr_ready", {31'd0, wr_ready}, 32'd1);
    end
  end

  task automatic cyc(input bit v, input [4:0] wr, input [2:0] ws, input [31:0] wd,
                     input [4:0] rr, input [2:0] rs);
    @(negedge clk); #1;
    wr_valid = v; wr_reg = wr; wr_sel = ws; wr_data = wd; rd_reg = rr; rd_sel = rs;
  endtask

  task automatic wrd(input [4:0] r, input [2:0] s, input [31:0] d);
    cyc(1'b1, r, s, d, r, s);
    cyc(1'b0, 5'd0, 3'd0, 32'd0, r, s);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // reset state of every address (R12 for unimplemented ones)
    for (int r = 0; r < 32; r++) cyc(1'b0, 5'd0, 3'd0, 32'd0, 5'(r), 3'd0);
    @(negedge clk); #1; rst_n = 1'b1;
    for (int r = 0; r < 32; r++) cyc(1'b0, 5'd0, 3'd0, 32'd0, 5'(r), 3'd0);
    // all-ones then pattern through every register: R2 R3 R4 R10 R11 R12 R13
    for (int r = 0; r < 32; r++) begin
      if (r == 12) continue;
      wrd(5'(r), 3'd0, 32'hFFFF_FFFF);
      wrd(5'(r), 3'd0, 32'hA5A5_5A5A);
    end
    wrd(5'd16, 3'd0, 32'd0);                      // R11 config keep
    wrd(5'd16, 3'd1, 32'hFFFF_FFFF);              // R11 alternate read-only
    wrd(5'd28, 3'd1, 32'hFFFF_FFFF);              // R11 data tag reads zero
    // R1: illegal selects discard writes
    wrd(5'd14, 3'd0, 32'h1234_5678);
    wrd(5'd14, 3'd2, 32'hDEAD_BEEF);
    cyc(1'b0, 5'd0, 3'd0, 32'd0, 5'd14, 3'd0);
    wrd(5'd16, 3'd5, 32'hFFFF_FFFF);
    cyc(1'b0, 5'd0, 3'd0, 32'd0, 5'd16, 3'd0);
    // R5: flush only on ASID change
    wrd(5'd10, 3'd0, 32'h0000_2012);
    wrd(5'd10, 3'd0, 32'h4000_0012);
    wrd(5'd10, 3'd0, 32'h4000_0013);
    cyc(1'b1, 5'd10, 3'd0, 32'h0000_0055, 5'd10, 3'd0);
    cyc(1'b1, 5'd10, 3'd0, 32'h0000_0066, 5'd10, 3'd0);
    cyc(1'b0, 5'd0, 3'd0, 32'd0, 5'd10, 3'd0);
    // R9: hardware lines into cause
    hw_irq_lines = 6'b000001;
    wrd(5'd13, 3'd0, 32'hFFFF_FFFF);
    // R7/R8 interrupt gating
    wrd(5'd12, 3'd0, 32'h0000_0401);              // raise
    wrd(5'd12, 3'd0, 32'h0000_0401);              // already enabled: hold
    wrd(5'd12, 3'd0, 32'h0000_0400);              // withdraw
    wrd(5'd12, 3'd0, 32'h0000_0403);              // exl blocks raise
    wrd(5'd12, 3'd0, 32'h0000_0000);
    wrd(5'd12, 3'd0, 32'h0000_0405);              // erl blocks raise
    wrd(5'd12, 3'd0, 32'h0000_0000);
    debug_mode = 1'b1;
    wrd(5'd12, 3'd0, 32'h0000_0401);              // debug blocks raise
    debug_mode = 1'b0;
    wrd(5'd12, 3'd0, 32'h0000_0010);              // user mode flag
    hw_irq_lines = 6'd0;
    wrd(5'd12, 3'd0, 32'h0000_0401);              // no pending line
    wrd(5'd12, 3'd0, 32'h0000_0000);
    wrd(5'd13, 3'd0, 32'h0000_0100);              // software request bit 8
    wrd(5'd12, 3'd0, 32'h0000_0101);              // raise from software bit
    wrd(5'd12, 3'd0, 32'h0000_0000);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] r;
      logic [2:0] s;
      r = 5'($urandom % 32);
      s = ($urandom % 5 == 0) ? 3'($urandom % 3) : 3'd0;
      if ($urandom % 8 == 0) hw_irq_lines = 6'($urandom);
      if ($urandom % 16 == 0) debug_mode = ~debug_mode;
      cyc(1'($urandom % 2), r, s, ($urandom % 2) ? $urandom : ($urandom & 32'h0000_FF07),
          5'($urandom % 32), ($urandom % 6 == 0) ? 3'd1 : 3'd0);
    end
    cyc(1'b0, 5'd0, 3'd0, 32'd0, 5'd0, 3'd0);
    cyc(1'b0, 5'd0, 3'd0, 32'd0, 5'd0, 3'd0);
    summary();
  end
endmodule